// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. The character format is chosen at run time: an optional parity bit with even or odd sense, and one or two stop bits. The transmitter takes a byte through a valid/ready handshake. It sends a low start bit, then the eight data bits least significant bit first, then the optional parity bit, then the stop bits. The line idles high.

The receiver oversamples its line at sixteen ticks per bit. It rejects a start bit that does not last to the middle of the bit. It returns each byte as a one-cycle valid pulse, with a parity-error flag and a framing-error flag that are valid in the same cycle. The receiver checks only the first stop bit. Once that stop bit has been sampled, a low line is taken as the start of the next character, even when two stop bits are configured.

Both directions share one baud generator. The generator first applies a four-way prescaler to the system clock: divide by 1, 4, 16 or 64. It then divides by the bit-rate divider plus one, which gives the sixteen-times oversampling tick.

Top module: `uart_xcvr`

## Requirements
- R1: While reset is high, and on the first cycle after it, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0. A reset in the middle of a frame returns the line to idle high.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next edge, `txd` carries a low start bit and then data bits 0 to 7 in that order. `tx_ready` stays 0 until the frame ends, and `txd` stays high while idle.
- R3: When `par_en` is 1, a parity bit follows data bit 7. With `par_odd` = 0 its value makes the count of ones in data plus parity even. With `par_odd` = 1 that count is odd.
- R4: With `stop_two` = 0 the frame ends with one high stop bit; with `stop_two` = 1 it ends with two. `tx_ready` returns to 1 exactly 16 × (bit-time ticks) × (frame bits) clock cycles after the accepting edge.
- R5: One bit lasts 16 × 4^`clk_sel` × (`rate_div` + 1) clock cycles, for `clk_sel` encodings 0 to 3.
- R6: Each received character raises `rx_valid` for exactly one cycle, with the byte on `rx_data`. `rx_par_err` and `rx_frm_err` are 0 whenever `rx_valid` is 0.
- R7: When parity is enabled, a received parity bit that does not match the `par_odd` sense sets `rx_par_err` with the byte.
- R8: A first stop bit sampled low sets `rx_frm_err`, and the byte is still delivered.
- R9: The receiver checks only the first stop bit. A start bit that follows the first stop bit directly begins a new character, whatever the setting of `stop_two`.
- R10: A low pulse on `rxd` that has ended by the middle of the start bit produces no character.
- R11: Framing settings are captured at the start of each character. A change during a frame does not alter the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| stop_two | input | 1 | Transmit stop length: 0 one bit, 1 two bits |
| clk_sel | input | 2 | Prescaler: 0 /1, 1 /4, 2 /16, 3 /64 |
| rate_div | input | 8 | Bit-rate divider; the tick period is (rate_div+1) prescaled clocks |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter idle and able to accept a byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is received |
| rx_par_err | output | 1 | Parity mismatch, valid with rx_valid |
| rx_frm_err | output | 1 | First stop bit low, valid with rx_valid |

## Verification
The transmitter always produces well-formed frames, so a loopback alone can never show the receiver's error paths or its second-stop behaviour. The bench therefore switches `rxd` from loopback to a bit-level driver. That driver builds frames with a low stop bit, frames with a wrong parity bit, a start glitch shorter than half a bit, and two characters placed back to back with no second stop bit between them. The prescaler cases are measured on a single isolated data bit in loopback, because the first start bit after a request can be shortened by the phase of the shared tick.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4
  } ser_state_e;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic stop_two;
  } frame_cfg_t;
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  // prescale ratios are powers of four: 4^sel
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] pre_lim;
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_hit;

  always_comb begin
    span    = (PRE_W+1)'(1) << {clk_sel, 1'b0};
    pre_lim = PRE_W'(span - (PRE_W+1)'(1));
    pre_hit = (pre_cnt >= pre_lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      pre_cnt <= pre_hit ? '0 : pre_cnt + 1'b1;
      if (pre_hit) begin
        if (div_cnt >= rate_div) begin
          div_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  frame_cfg_t        cfg_in,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd
);
  localparam int TC_W = $clog2(OVS);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVS - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  ser_state_e        st;
  frame_cfg_t        cfg;
  logic [DATA_W-1:0] sh;
  logic [TC_W-1:0]   tcnt;
  logic [BC_W-1:0]   bitn;
  logic              par_bit;
  logic              stop_more;
  logic              bit_end;

  assign tx_ready = (st == S_IDLE);
  assign bit_end  = tick && (tcnt == TC_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cfg       <= '0;
      sh        <= '0;
      tcnt      <= '0;
      bitn      <= '0;
      par_bit   <= 1'b0;
      stop_more <= 1'b0;
      txd       <= 1'b1;
    end else if (st == S_IDLE) begin
      txd <= 1'b1;
      if (tx_valid) begin
        st      <= S_START;
        cfg     <= cfg_in;
        sh      <= tx_data;
        par_bit <= (^tx_data) ^ cfg_in.par_odd;
        tcnt    <= '0;
        txd     <= 1'b0;
      end
    end else begin
      if (tick) tcnt <= tcnt + 1'b1;
      if (bit_end) begin
        tcnt <= '0;
        unique case (st)
          S_START: begin
            st   <= S_DATA;
            bitn <= '0;
            txd  <= sh[0];
          end
          S_DATA: begin
            if (bitn == BC_LAST) begin
              if (cfg.par_en) begin
                st  <= S_PAR;
                txd <= par_bit;
              end else begin
                st        <= S_STOP;
                txd       <= 1'b1;
                stop_more <= cfg.stop_two;
              end
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= sh >> 1;
              txd  <= sh[1];
            end
          end
          S_PAR: begin
            st        <= S_STOP;
            txd       <= 1'b1;
            stop_more <= cfg.stop_two;
          end
          S_STOP: begin
            if (stop_more) stop_more <= 1'b0;
            else           st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  frame_cfg_t        cfg_in,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  localparam int TC_W = $clog2(OVS);
  localparam int BC_W = $clog2(DATA_W);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(OVS - 1);
  localparam logic [TC_W-1:0] TC_MID  = TC_W'(OVS / 2 - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DATA_W - 1);

  ser_state_e        st;
  logic [1:0]        sync;
  logic              rx_s;
  logic              cf_par_en;
  logic              cf_par_odd;
  logic [DATA_W-1:0] sh;
  logic [TC_W-1:0]   tcnt;
  logic [BC_W-1:0]   bitn;
  logic              perr;
  logic              samp;

  assign rx_s = sync[1];
  assign samp = tick && (tcnt == TC_LAST);

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cf_par_en  <= 1'b0;
      cf_par_odd <= 1'b0;
      sh         <= '0;
      tcnt       <= '0;
      bitn       <= '0;
      perr       <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (!rx_s) begin
            st         <= S_START;
            tcnt       <= '0;
            perr       <= 1'b0;
            cf_par_en  <= cfg_in.par_en;
            cf_par_odd <= cfg_in.par_odd;
          end
        end
        S_START: begin
          if (tick) begin
            if (tcnt == TC_MID) begin
              tcnt <= '0;
              bitn <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (samp) begin
            tcnt <= '0;
            sh   <= {rx_s, sh[DATA_W-1:1]};
            if (bitn == BC_LAST) st <= cf_par_en ? S_PAR : S_STOP;
            else                 bitn <= bitn + 1'b1;
          end
        end
        S_PAR: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (samp) begin
            tcnt <= '0;
            perr <= rx_s ^ (^sh) ^ cf_par_odd;
            st   <= S_STOP;
          end
        end
        S_STOP: begin
          if (tick) tcnt <= tcnt + 1'b1;
          if (samp) begin
            // only this stop bit is examined; the line is watched again at once
            tcnt       <= '0;
            rx_data    <= sh;
            rx_valid   <= 1'b1;
            rx_par_err <= perr & cf_par_en;
            rx_frm_err <= ~rx_s;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
  import uart_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int SEL_W  = 2,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_two,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [DIV_W-1:0]  rate_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err
);
  logic       tick;
  frame_cfg_t cfg;

  assign cfg = '{par_en: par_en, par_odd: par_odd, stop_two: stop_two};

  uart_baud #(.SEL_W(SEL_W), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .rate_div(rate_div), .tick(tick)
  );

  uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .cfg_in(cfg),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd)
  );

  uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .cfg_in(cfg), .rxd(rxd),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );
endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rst,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic rx_valid,
  input logic rx_par_err,
  input logic rx_frm_err
);
  // R2
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd);

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R2
  idle_line_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && $past(tx_ready) && !$past(rst)) |-> $stable(txd));

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R6
  rx_flag_qual_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> !(rx_par_err || rx_frm_err));
endmodule

bind uart_xcvr uart_xcvr_chk u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
);

// File: tb/tb_uart_xcvr.sv
module tb_uart_xcvr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] rate_div = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, rxd;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err;
  logic       loop = 1'b1;
  logic       raw_rx = 1'b1;

  int checks = 0, errors = 0, cyc = 0, rx_cnt = 0;
  logic [7:0] last_data;
  logic       last_pe, last_fe;
  bit         done = 0;

  assign rxd = loop ? txd : raw_rx;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rx_valid) begin
    rx_cnt    <= rx_cnt + 1;
    last_data <= rx_data;
    last_pe   <= rx_par_err;
    last_fe   <= rx_frm_err;
  end

  uart_xcvr dut (
    .clk(clk), .rst(rst), .par_en(par_en), .par_odd(par_odd), .stop_two(stop_two),
    .clk_sel(clk_sel), .rate_div(rate_div), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  // {stop_two, par_odd, par_en, data}
  localparam logic [10:0] VEC [8] = '{
    {3'b000, 8'h55}, {3'b001, 8'h01}, {3'b011, 8'h01}, {3'b101, 8'hFF},
    {3'b111, 8'h00}, {3'b100, 8'h80}, {3'b011, 8'hA7}, {3'b001, 8'h3C}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    while (!tx_ready) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_ready();
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic drive_bits(input logic [15:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      raw_rx = bits[i];
      repeat (16) @(negedge clk);
    end
  endtask

  task automatic measure_bit(input logic [1:0] sel, input logic [7:0] dv, input int exp);
    int r, f, base;
    clk_sel = sel; rate_div = dv; par_en = 0; stop_two = 0; loop = 1;
    base = rx_cnt;
    send_byte(8'h01);
    while (txd == 1'b0) @(negedge clk);
    r = cyc;
    while (txd == 1'b1) @(negedge clk);
    f = cyc;
    check(f - r == exp, "R5 bit period", f - r, exp);
    wait_ready();
    repeat (4) @(negedge clk);
    check(rx_cnt == base + 1 && last_data == 8'h01, "R5 loopback at prescaled rate", last_data, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
    end
  end

  initial begin
    int c0, base, nbits;
    logic [7:0] d;
    logic s2, od, pe;
    repeat (3) @(negedge clk);
    check(txd == 1 && tx_ready == 1 && rx_valid == 0, "R1 in reset", {txd, tx_ready, rx_valid}, 3'b110);
    rst = 1'b0;
    @(negedge clk);
    check(txd == 1 && tx_ready == 1 && rx_valid == 0, "R1 after reset", {txd, tx_ready, rx_valid}, 3'b110);
    repeat (4) @(negedge clk);

    // table walk in loopback, tick every clock so a bit is 16 cycles
    for (int v = 0; v < 8; v++) begin
      {s2, od, pe, d} = VEC[v];
      stop_two = s2; par_odd = od; par_en = pe; loop = 1;
      base = rx_cnt;
      send_byte(d);
      c0 = cyc;
      repeat (8) @(negedge clk);
      check(txd == 0, "R2 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (16) @(negedge clk);
        check(txd == d[i], "R2 data bit order", txd, d[i]);
      end
      if (pe) begin
        repeat (16) @(negedge clk);
        check(txd == ((^d) ^ od), "R3 parity bit", txd, (^d) ^ od);
      end
      for (int k = 0; k < (s2 ? 2 : 1); k++) begin
        repeat (16) @(negedge clk);
        check(txd == 1, "R4 stop bit", txd, 1);
      end
      nbits = 10 + (pe ? 1 : 0) + (s2 ? 1 : 0);
      wait_ready();
      check(cyc - c0 == 16 * nbits, "R4 frame length", cyc - c0, 16 * nbits);
      repeat (4) @(negedge clk);
      check(rx_cnt == base + 1, "R6 one byte delivered", rx_cnt - base, 1);
      check(last_data == d && !last_pe && !last_fe, "R6 loopback data and flags",
            {last_pe, last_fe, last_data}, {2'b00, d});
    end

    // R11: settings change in mid-frame
    par_en = 0; stop_two = 0; par_odd = 0;
    base = rx_cnt;
    send_byte(8'h96);
    c0 = cyc;
    repeat (40) @(negedge clk);
    par_en = 1; stop_two = 1;
    wait_ready();
    check(cyc - c0 == 160, "R11 frame keeps captured format", cyc - c0, 160);
    repeat (4) @(negedge clk);
    check(rx_cnt == base + 1 && last_data == 8'h96 && !last_pe && !last_fe,
          "R11 byte intact", {last_pe, last_fe, last_data}, 10'h096);
    par_en = 0; stop_two = 0;

    // raw receive tests
    loop = 0; raw_rx = 1;
    repeat (20) @(negedge clk);

    // R10: short start glitch
    base = rx_cnt;
    raw_rx = 0; repeat (4) @(negedge clk); raw_rx = 1;
    repeat (400) @(negedge clk);
    check(rx_cnt == base, "R10 glitch rejected", rx_cnt - base, 0);

    // R8: low stop bit
    base = rx_cnt;
    drive_bits({6'h3F, 1'b0, 8'hA5, 1'b0}, 10);
    raw_rx = 1; repeat (40) @(negedge clk);
    check(rx_cnt == base + 1 && last_data == 8'hA5, "R8 byte still delivered", last_data, 8'hA5);
    check(last_fe == 1 && last_pe == 0, "R8 framing flag", {last_fe, last_pe}, 2'b10);

    // R7: wrong parity (data 0x03 even ones, even sense wants 0, send 1)
    par_en = 1; par_odd = 0;
    base = rx_cnt;
    drive_bits({5'h1F, 1'b1, 1'b1, 8'h03, 1'b0}, 11);
    repeat (40) @(negedge clk);
    check(rx_cnt == base + 1 && last_pe == 1 && last_fe == 0, "R7 parity error flagged",
          {last_pe, last_fe}, 2'b10);
    // R7: odd sense, data 0x03 needs parity 1
    par_odd = 1;
    base = rx_cnt;
    drive_bits({5'h1F, 1'b1, 1'b1, 8'h03, 1'b0}, 11);
    repeat (40) @(negedge clk);
    check(rx_cnt == base + 1 && last_pe == 0 && last_data == 8'h03, "R7 odd parity accepted",
          last_pe, 0);
    par_en = 0; par_odd = 0;

    // R9: two-stop setting, next start right after first stop
    stop_two = 1;
    base = rx_cnt;
    drive_bits({6'h3F, 1'b1, 8'h3C, 1'b0}, 10);
    drive_bits({6'h3F, 1'b1, 8'hC3, 1'b0}, 10);
    raw_rx = 1; repeat (40) @(negedge clk);
    check(rx_cnt == base + 2, "R9 back-to-back characters", rx_cnt - base, 2);
    check(last_data == 8'hC3 && !last_fe, "R9 second character clean", {last_fe, last_data}, 9'h0C3);
    stop_two = 0;

    // R5: prescaler and divider
    measure_bit(2'd1, 8'd1, 128);
    measure_bit(2'd2, 8'd2, 768);
    measure_bit(2'd3, 8'd0, 1024);
    clk_sel = 0; rate_div = 0;

    // R1: reset in mid-frame
    repeat (20) @(negedge clk);
    send_byte(8'h00);
    repeat (50) @(negedge clk);
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    check(txd == 1 && tx_ready == 1, "R1 reset mid-frame", {txd, tx_ready}, 2'b11);

    summary();
  end
endmodule